// File: doc/BRIEF.md
# Brushed-DC H-Bridge Control Decoder

This block turns the command inputs of a brushed-DC motor channel into the gate-level states of the two half-bridges of an H-bridge. Each half-bridge output can be sourced high, sunk low, or left floating. The block also reports which kind of current decay is in progress and whether synchronous rectification is on. The command set is a direction bit, an enable bit and a decay-select bit. Two flags come from the analog side: a registered current-limit trip flag and a zero-current flag.

Dropping the enable does not float the bridge. It enters braking (slow decay) or reverse-polarity (fast decay) recirculation, chosen by the decay-select bit. A current-limit trip while enabled reuses the same two recirculation patterns. During fast decay the bridge floats once the winding current reaches zero, so the current cannot build up in the wrong direction. An overcurrent event latches a fault that shuts the bridge off until sleep is requested or the block is reset. A separate, non-latching fault input shuts the bridge off only while it is held.

Every output is registered. The outputs show the decision taken on the inputs present at the previous rising clock edge.

Top module: `dcb_bridge_ctrl`

## Requirements
- R1: While reset is held, both half-bridge outputs read OFF (code 0), the decay code reads IDLE (code 3) and the rectification flag reads 0. Half-bridge codes are OFF=0, LOW=1, HIGH=2. Decay codes are DRIVE=0, SLOW=1, FAST=2, IDLE=3.
- R2: With enable high, no trip and no gating condition, direction 1 gives A=HIGH and B=LOW, and direction 0 gives A=LOW and B=HIGH. The decay code is DRIVE and rectification is 0.
- R3: With enable low and decay-select 1, both outputs are LOW whatever the direction. The decay code is SLOW and rectification is 1.
- R4: With enable low and decay-select 0, the outputs take the polarity opposite to the direction: direction 1 gives A=LOW and B=HIGH. The decay code is FAST and rectification is 1.
- R5: With enable high and trip high, decay-select 1 gives the R3 pattern and decay-select 0 gives the R4 pattern.
- R6: In a fast-decay state with the zero flag high, both outputs are OFF, the decay code stays FAST and rectification is 0. The zero flag has no effect in drive or slow-decay states.
- R7: With HOLD_FLOAT=1, a bridge floated under R6 stays floated while the decoded state remains fast decay, even after the zero flag falls. It is released once the state is not fast decay. With HOLD_FLOAT=0, floating follows the zero flag cycle by cycle.
- R8: An overcurrent pulse sampled while sleep is low turns both outputs OFF with decay code IDLE and rectification 0, in the same update. This state persists after the pulse ends.
- R9: Sleep forces OFF/IDLE with rectification 0 and clears the overcurrent latch. Overcurrent pulses sampled during sleep are ignored. No other input clears the latch.
- R10: The non-latching fault input forces OFF/IDLE with rectification 0 only in the updates that follow cycles where it is high.
- R11: Each output update reflects the inputs sampled at the preceding rising edge.
- R12: The two half-bridge outputs are never HIGH at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dir_i | input | 1 | Direction command |
| enable_i | input | 1 | Enable; low selects recirculation |
| slow_sel_i | input | 1 | Decay select: 1 slow (brake), 0 fast (reverse) |
| trip_i | input | 1 | Registered current-limit trip flag |
| zero_i | input | 1 | Winding current near zero |
| ocp_i | input | 1 | Overcurrent detect, latched inside |
| sleep_i | input | 1 | Sleep request, active high |
| hold_fault_i | input | 1 | Non-latching fault (thermal or supply) |
| out_a_o | output | 2 | Half-bridge A state code |
| out_b_o | output | 2 | Half-bridge B state code |
| decay_o | output | 2 | Decay state code |
| sr_on_o | output | 1 | Synchronous rectification active |

## Verification
The bench builds two copies side by side: one with HOLD_FLOAT=1 and one with HOLD_FLOAT=0. Both are compared each cycle against one behavioural model. A zero flag that chatters during a long fast-decay interval therefore shows both float policies on the same stimulus. Directed sequences cover the overcurrent latch through pulse, persistence and sleep release. Random traffic then mixes trips, gating inputs and zero-flag toggles, so that every priority between them is reached.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  typedef enum logic [1:0] {
    HB_OFF  = 2'd0,
    HB_LOW  = 2'd1,
    HB_HIGH = 2'd2
  } hb_e;

  typedef enum logic [1:0] {
    DK_DRIVE = 2'd0,
    DK_SLOW  = 2'd1,
    DK_FAST  = 2'd2,
    DK_IDLE  = 2'd3
  } decay_e;

  typedef struct packed {
    hb_e    a;
    hb_e    b;
    decay_e dk;
    logic   sr;
  } bridge_cmd_t;

  localparam bridge_cmd_t CMD_IDLE = '{a: HB_OFF, b: HB_OFF, dk: DK_IDLE, sr: 1'b0};

endpackage

// File: rtl/dcb_rst_sync.sv
module dcb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/dcb_pattern.sv
module dcb_pattern
  import dcb_pkg::*;
(
  input  logic        dir_i,
  input  logic        enable_i,
  input  logic        slow_sel_i,
  input  logic        trip_i,
  output bridge_cmd_t cmd_o,
  output logic        fast_o
);
  logic recirc;

  always_comb begin
    recirc = !enable_i || trip_i;
    fast_o = 1'b0;
    if (!recirc) begin
      cmd_o.a  = dir_i ? HB_HIGH : HB_LOW;
      cmd_o.b  = dir_i ? HB_LOW  : HB_HIGH;
      cmd_o.dk = DK_DRIVE;
      cmd_o.sr = 1'b0;
    end else if (slow_sel_i) begin
      cmd_o.a  = HB_LOW;
      cmd_o.b  = HB_LOW;
      cmd_o.dk = DK_SLOW;
      cmd_o.sr = 1'b1;
    end else begin
      cmd_o.a  = dir_i ? HB_LOW  : HB_HIGH;
      cmd_o.b  = dir_i ? HB_HIGH : HB_LOW;
      cmd_o.dk = DK_FAST;
      cmd_o.sr = 1'b1;
      fast_o   = 1'b1;
    end
  end
endmodule

// File: rtl/dcb_fault_latch.sv
module dcb_fault_latch (
  input  logic clk,
  input  logic rst_sn,
  input  logic sleep_i,
  input  logic ocp_i,
  output logic fault_q_o,
  output logic fault_now_o
);
  logic fault_q;
  logic fault_n;
  logic fault_en;

  always_comb begin
    fault_en = sleep_i || (ocp_i && !fault_q);
    fault_n  = sleep_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)       fault_q <= 1'b0;
    else if (fault_en) fault_q <= fault_n;
  end

  assign fault_q_o   = fault_q;
  assign fault_now_o = fault_q || (ocp_i && !sleep_i);
endmodule

// File: rtl/dcb_zero_guard.sv
module dcb_zero_guard #(
  parameter bit HOLD_FLOAT = 1'b1
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic fast_i,
  input  logic zero_i,
  output logic float_o
);
  generate
    if (HOLD_FLOAT) begin : g_hold
      logic float_q;
      logic float_n;
      always_comb begin
        float_n = fast_i && (zero_i || float_q);
      end
      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) float_q <= 1'b0;
        else         float_q <= float_n;
      end
      assign float_o = float_n;
    end else begin : g_follow
      assign float_o = fast_i && zero_i;
    end
  endgenerate
endmodule

// File: rtl/dcb_bridge_ctrl.sv
module dcb_bridge_ctrl
  import dcb_pkg::*;
#(
  parameter bit HOLD_FLOAT  = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_i,
  input  logic       enable_i,
  input  logic       slow_sel_i,
  input  logic       trip_i,
  input  logic       zero_i,
  input  logic       ocp_i,
  input  logic       sleep_i,
  input  logic       hold_fault_i,
  output logic [1:0] out_a_o,
  output logic [1:0] out_b_o,
  output logic [1:0] decay_o,
  output logic       sr_on_o
);
  logic        rst_sn;
  bridge_cmd_t pat_cmd;
  logic        pat_fast;
  logic        fault_lat;
  logic        fault_now;
  logic        gate_off;
  logic        fast_live;
  logic        floated;
  bridge_cmd_t cmd_n;
  bridge_cmd_t cmd_q;

  dcb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  dcb_pattern u_pat (
    .dir_i(dir_i), .enable_i(enable_i), .slow_sel_i(slow_sel_i),
    .trip_i(trip_i), .cmd_o(pat_cmd), .fast_o(pat_fast)
  );

  dcb_fault_latch u_fault (
    .clk(clk), .rst_sn(rst_sn), .sleep_i(sleep_i), .ocp_i(ocp_i),
    .fault_q_o(fault_lat), .fault_now_o(fault_now)
  );

  always_comb begin
    gate_off  = sleep_i || fault_now || hold_fault_i;
    fast_live = pat_fast && !gate_off;
  end

  dcb_zero_guard #(.HOLD_FLOAT(HOLD_FLOAT)) u_zero (
    .clk(clk), .rst_sn(rst_sn), .fast_i(fast_live), .zero_i(zero_i),
    .float_o(floated)
  );

  always_comb begin
    if (gate_off) begin
      cmd_n = CMD_IDLE;
    end else if (floated) begin
      cmd_n = '{a: HB_OFF, b: HB_OFF, dk: DK_FAST, sr: 1'b0};
    end else begin
      cmd_n = pat_cmd;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cmd_q <= CMD_IDLE;
    else         cmd_q <= cmd_n;
  end

  assign out_a_o = cmd_q.a;
  assign out_b_o = cmd_q.b;
  assign decay_o = cmd_q.dk;
  assign sr_on_o = cmd_q.sr;
endmodule

// File: rtl/dcb_bridge_ctrl_chk.sv
module dcb_bridge_ctrl_chk (
  input logic       clk,
  input logic       rst_sn,
  input logic       enable_i,
  input logic       slow_sel_i,
  input logic       ocp_i,
  input logic       sleep_i,
  input logic       hold_fault_i,
  input logic       fault_lat,
  input logic [1:0] out_a_o,
  input logic [1:0] out_b_o,
  input logic [1:0] decay_o,
  input logic       sr_on_o
);
  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_sn)
    !(out_a_o == 2'd2 && out_b_o == 2'd2)); // R12

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(sleep_i) |-> (out_a_o == 2'd0 && out_b_o == 2'd0 && decay_o == 2'd3)); // R9

  AST_OCP_OFF: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(ocp_i) && !$past(sleep_i)) |-> (out_a_o == 2'd0 && out_b_o == 2'd0 && !sr_on_o)); // R8

  AST_HOLD_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(hold_fault_i) |-> (decay_o == 2'd3 && !sr_on_o)); // R10

  AST_BRAKE_LOW: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(!enable_i && slow_sel_i && !sleep_i && !ocp_i && !hold_fault_i && !fault_lat)
    |-> (out_a_o == 2'd1 && out_b_o == 2'd1 && sr_on_o)); // R3

  AST_DRIVE_NO_SR: assert property (@(posedge clk) disable iff (!rst_sn)
    (decay_o == 2'd0) |-> !sr_on_o); // R2
endmodule

bind dcb_bridge_ctrl dcb_bridge_ctrl_chk u_chk (
  .clk(clk), .rst_sn(rst_sn), .enable_i(enable_i), .slow_sel_i(slow_sel_i),
  .ocp_i(ocp_i), .sleep_i(sleep_i), .hold_fault_i(hold_fault_i),
  .fault_lat(fault_lat), .out_a_o(out_a_o), .out_b_o(out_b_o),
  .decay_o(decay_o), .sr_on_o(sr_on_o)
);

// File: tb/dcb_bridge_ctrl_tb.sv
module dcb_bridge_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic dir, en, slw, trp, zro, ocp, slp, hft;
  logic [1:0] a1, b1, d1, a0, b0, d0;
  logic       s1, s0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit m_fault;
  bit m_float;

  always #10 clk = ~clk;

  dcb_bridge_ctrl #(.HOLD_FLOAT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_i(dir), .enable_i(en), .slow_sel_i(slw),
    .trip_i(trp), .zero_i(zro), .ocp_i(ocp), .sleep_i(slp), .hold_fault_i(hft),
    .out_a_o(a1), .out_b_o(b1), .decay_o(d1), .sr_on_o(s1)
  );

  dcb_bridge_ctrl #(.HOLD_FLOAT(1'b0)) u_dut_nh (
    .clk(clk), .rst_n(rst_n), .dir_i(dir), .enable_i(en), .slow_sel_i(slw),
    .trip_i(trp), .zero_i(zro), .ocp_i(ocp), .sleep_i(slp), .hold_fault_i(hft),
    .out_a_o(a0), .out_b_o(b0), .decay_o(d0), .sr_on_o(s0)
  );

  task automatic cmp(input string tag, input string which,
                     input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual a=%0d b=%0d dk=%0d sr=%0d expected a=%0d b=%0d dk=%0d sr=%0d",
               tag, which, act[6:5], act[4:3], act[2:1], act[0],
               exp[6:5], exp[4:3], exp[2:1], exp[0]);
    end
  endtask

  // Behavioural model: codes OFF=0 LOW=1 HIGH=2; DRIVE=0 SLOW=1 FAST=2 IDLE=3.
  // One step: apply inputs, wait one rising edge, outputs reflect them (R11).
  task automatic step(input bit ph, input bit e, input bit m, input bit t,
                      input bit z, input bit o, input bit s, input bit h);
    int pa, pb, pd, ps;
    bit gate, fast, fl1, fl0;
    string tag;
    logic [6:0] e1, e0;
    dir = ph; en = e; slw = m; trp = t; zro = z; ocp = o; slp = s; hft = h;
    @(posedge clk);
    #2;
    gate = s || m_fault || (o && !s) || h;
    if (e && !t) begin
      pa = ph ? 2 : 1; pb = ph ? 1 : 2; pd = 0; ps = 0; tag = "R2";
    end else if (m) begin
      pa = 1; pb = 1; pd = 1; ps = 1; tag = e ? "R5" : "R3";
    end else begin
      pa = ph ? 1 : 2; pb = ph ? 2 : 1; pd = 2; ps = 1; tag = e ? "R5" : "R4";
    end
    fast = (pd == 2) && !gate;
    if (z && !fast) tag = "R6";
    fl1 = fast && (z || m_float);
    fl0 = fast && z;
    if (s) tag = "R9";
    else if (m_fault || o) tag = "R8";
    else if (h) tag = "R10";
    else if (fl1 && !z) tag = "R7";
    else if (fl1) tag = "R6";
    if (gate) begin
      e1 = {2'd0, 2'd0, 2'd3, 1'b0}; e0 = e1;
    end else begin
      e1 = fl1 ? {2'd0, 2'd0, 2'd2, 1'b0} : {pa[1:0], pb[1:0], pd[1:0], ps[0]};
      e0 = fl0 ? {2'd0, 2'd0, 2'd2, 1'b0} : {pa[1:0], pb[1:0], pd[1:0], ps[0]};
    end
    cmp(tag, "hold", {a1, b1, d1, s1}, e1);
    cmp(tag, "follow", {a0, b0, d0, s0}, e0);
    m_float = fl1;
    m_fault = s ? 1'b0 : (m_fault || o);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    dir = 0; en = 0; slw = 0; trp = 0; zro = 0; ocp = 0; slp = 1; hft = 0;
    m_fault = 0; m_float = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    cmp("R1", "hold", {a1, b1, d1, s1}, {2'd0, 2'd0, 2'd3, 1'b0});
    cmp("R1", "follow", {a0, b0, d0, s0}, {2'd0, 2'd0, 2'd3, 1'b0});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0, 0, 1, 0);
    // R2 drive both directions; R11 latency covered by step sampling
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 1, 0, 0, 0);            // R6 zero ignored in drive
    // R3 brake, either direction, zero ignored
    step(1, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0, 0, 0);
    // R4 reverse fast decay
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // R5 trip chopping
    step(1, 1, 1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 1, 0, 0, 0, 0);
    // R6/R7 zero during fast decay then drops
    step(1, 0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);            // R7 release on leaving fast decay
    step(1, 0, 0, 0, 0, 0, 0, 0);
    // R8 overcurrent latch
    step(1, 1, 0, 0, 0, 1, 0, 0);
    repeat (4) step(1, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    // R9 sleep clears; ocp during sleep ignored
    step(1, 1, 0, 0, 0, 1, 1, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    // R10 non-latching fault
    step(1, 1, 0, 0, 0, 0, 0, 1);
    step(1, 1, 0, 0, 0, 0, 0, 1);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      step(r[0], r[1] | r[2], r[3], r[4] & r[5], r[6] & r[7],
           (r[15:8] == 8'd3), (r[23:16] < 8'd4), (r[31:24] < 8'd6));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule